// File: doc/BRIEF.md
# Prioritized Address Window Decoder

This block decides, for every transaction presented on its request port, which target interface should receive it. The 36-bit transaction address is compared against three classes of programmable windows: one configuration-register window, a small set of on-chip SRAM windows and a bank of local access windows. Each window has a power-of-two size, and only the address bits above that size take part in the comparison. A fixed precedence chooses among the classes. When nothing claims the address, a boot ROM region and then a miss indication follow. The result is registered and comes out one cycle after the request.

A single write port programs the windows. The configuration window has a programmable base only: it is always on, its size is fixed at 1 MB and it carries no attribute field. The SRAM and local access windows each take a base, a size code, an enable and a target ID. SRAM windows only claim snoopable traffic. Non-snooped accesses that fall in an SRAM range drop through to the local access windows. Nothing is translated; the block reports a target, a class and a window index.

Top module: `addr_window_decoder`

## Requirements
- R1: `resp_valid` equals `req_valid` of the previous cycle. A lookup result appears one cycle after the request. When `resp_valid` is low, `resp_hit`, `resp_miss`, `resp_class`, `resp_target` and `resp_index` are all 0, and all are 0 after reset.
- R2: The configuration window is always enabled and covers 1 MB. Its base comes out of reset as `CFG_RESET_BASE`, and a write with `wr_class`=0 replaces it, with the low 20 bits cleared. A hit reports `resp_class`=1, `resp_target`=`CFG_TGT` and `resp_index`=0.
- R3: A configuration window hit wins over every SRAM window and every local access window that matches the same address.
- R4: An enabled SRAM window with a legal size claims a snoopable request (`req_snoop`=1) that falls in its range. It wins over local access windows and the boot region, and reports `resp_class`=2, its own target and its SRAM index; the lower index wins.
- R5: A request with `req_snoop`=0 never reports class 2. It is decoded by the local access windows, the boot region or the miss path, as if no SRAM window existed.
- R6: SRAM size codes 15, 16 and 17 (64 KB, 128 KB, 256 KB; size = 2^(code+1)) are legal. Any other code makes that SRAM window match nothing.
- R7: A local access window (`wr_class`=2) holds a base, an enable, a size code and a target. An enabled window hits when the address bits at and above position code+1 equal those of its base, and reports `resp_class`=3, its target and its index. When several overlap, the lowest index wins.
- R8: Local access size codes 11 to 35 (4 KB to 64 GB) are legal. Any other code makes that window match nothing.
- R9: A base that is written unaligned to its window's legal size is taken as its size-aligned value. The whole aligned block around the written value hits, and nothing outside it does.
- R10: A request that hits no window but falls in the 8 MB boot region at `BOOT_BASE` reports `resp_class`=4 and `resp_target`=`BOOT_TGT`, with index 0.
- R11: A request that hits nothing reports `resp_miss`=1, `resp_hit`=0, `resp_class`=0, target 0 and index 0.
- R12: Writes to an SRAM index at or above `NUM_SRAM`, and writes with `wr_class`=3, change nothing. A write takes effect for requests in later cycles, not for a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 36 | Transaction address |
| req_snoop | input | 1 | Transaction is snoopable or from a processor |
| wr_valid | input | 1 | Window write strobe |
| wr_class | input | 2 | Window class: 0 configuration, 1 SRAM, 2 local access, 3 none |
| wr_idx | input | 3 | Window index within the class |
| wr_base | input | 36 | New base address |
| wr_size | input | 6 | Size code, size = 2^(code+1) |
| wr_enable | input | 1 | Window enable |
| wr_target | input | 5 | Target interface ID |
| resp_valid | output | 1 | Lookup result valid |
| resp_hit | output | 1 | Some window or the boot region claimed the address |
| resp_miss | output | 1 | Nothing claimed the address |
| resp_class | output | 3 | 0 miss, 1 configuration, 2 SRAM, 3 local access, 4 boot |
| resp_target | output | 5 | Selected target ID |
| resp_index | output | 3 | Window index within the winning class |

## Verification
The hardest case to reach from the ports is a single address claimed at the same time by the configuration window, an SRAM window and two local access windows. The result must then change as the snoop flag, the enables and the size codes change. The stimulus builds this stack on purpose: it moves the configuration base over an SRAM window, places overlapping local access windows under both, and then peels the layers away one write at a time. A random phase then writes unaligned bases and illegal size codes. It aims addresses near the programmed bases, so overlaps and boundary addresses keep recurring. The bench model follows every write and every lookup cycle by cycle.

// File: rtl/awd_pkg.sv
package awd_pkg;

   localparam int SZ_W = 6;

   typedef enum logic [2:0] {
      CLS_MISS = 3'd0,
      CLS_CFG  = 3'd1,
      CLS_SRAM = 3'd2,
      CLS_LAW  = 3'd3,
      CLS_BOOT = 3'd4
   } resp_cls_e;

   typedef enum logic [1:0] {
      WR_CFG  = 2'd0,
      WR_SRAM = 2'd1,
      WR_LAW  = 2'd2,
      WR_NONE = 2'd3
   } wr_cls_e;

   // size code inside the legal range of a window class
   function automatic logic code_legal(logic [SZ_W-1:0] code, int lo, int hi);
      return (int'(code) >= lo) && (int'(code) <= hi);
   endfunction

endpackage

// File: rtl/awd_cfg_win.sv
module awd_cfg_win #(
   parameter int                ADDR_W     = 36,
   parameter int                LOG2       = 20,
   parameter logic [ADDR_W-1:0] RESET_BASE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit
);

   localparam logic [ADDR_W-1:0] KEEP = {ADDR_W{1'b1}} << LOG2;

   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      base_q <= RESET_BASE & KEEP;
      else if (wr_stb) base_q <= wr_base & KEEP;
   end

   assign lk_hit = ((lk_addr ^ base_q) & KEEP) == '0;

endmodule

// File: rtl/awd_win_bank.sv
module awd_win_bank
   import awd_pkg::*;
#(
   parameter int ADDR_W   = 36,
   parameter int TGT_W    = 5,
   parameter int NUM_WIN  = 8,
   parameter int IDX_W    = 3,
   parameter int CODE_MIN = 11,
   parameter int CODE_MAX = 35
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [SZ_W-1:0]   wr_size,
   input  logic              wr_enable,
   input  logic [TGT_W-1:0]  wr_target,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_idx,
   output logic [TGT_W-1:0]  lk_tgt
);

   // ones on the bits that take part in the comparison (above the size)
   function automatic logic [ADDR_W-1:0] above_mask(logic [SZ_W-1:0] code);
      logic [ADDR_W-1:0] m;
      m = '1;
      for (int b = 0; b < ADDR_W; b++)
         if (b <= int'(code)) m[b] = 1'b0;
      return m;
   endfunction

   logic [NUM_WIN-1:0] hit_v;
   logic [TGT_W-1:0]   tgt_a [NUM_WIN];
   logic [ADDR_W-1:0]  wr_mask;
   logic               wr_legal;

   assign wr_mask  = above_mask(wr_size);
   assign wr_legal = code_legal(wr_size, CODE_MIN, CODE_MAX);

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic [ADDR_W-1:0] base_q;
      logic [SZ_W-1:0]   size_q;
      logic              en_q;
      logic [TGT_W-1:0]  tgt_q;
      logic              sel;
      logic [ADDR_W-1:0] cmp_mask;

      assign sel = wr_stb && (int'(wr_idx) == w);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            en_q   <= 1'b0;
            tgt_q  <= '0;
         end else if (sel) begin
            base_q <= wr_legal ? (wr_base & wr_mask) : wr_base;
            size_q <= wr_size;
            en_q   <= wr_enable;
            tgt_q  <= wr_target;
         end
      end

      assign cmp_mask = above_mask(size_q);
      assign hit_v[w] = en_q && code_legal(size_q, CODE_MIN, CODE_MAX)
                        && (((lk_addr ^ base_q) & cmp_mask) == '0);
      assign tgt_a[w] = tgt_q;
   end

   // lowest index wins
   always_comb begin
      lk_hit = |hit_v;
      lk_idx = '0;
      lk_tgt = '0;
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (hit_v[w]) begin
            lk_idx = IDX_W'(w);
            lk_tgt = tgt_a[w];
         end
      end
   end

endmodule

// File: rtl/awd_select.sv
module awd_select
   import awd_pkg::*;
#(
   parameter int               TGT_W    = 5,
   parameter int               IDX_W    = 3,
   parameter logic [TGT_W-1:0] CFG_TGT  = '1,
   parameter logic [TGT_W-1:0] BOOT_TGT = '0
) (
   input  logic             snoop,
   input  logic             cfg_hit,
   input  logic             sram_hit,
   input  logic [IDX_W-1:0] sram_idx,
   input  logic [TGT_W-1:0] sram_tgt,
   input  logic             law_hit,
   input  logic [IDX_W-1:0] law_idx,
   input  logic [TGT_W-1:0] law_tgt,
   input  logic             boot_hit,
   output resp_cls_e        sel_cls,
   output logic [TGT_W-1:0] sel_tgt,
   output logic [IDX_W-1:0] sel_idx
);

   always_comb begin
      sel_cls = CLS_MISS;
      sel_tgt = '0;
      sel_idx = '0;
      if (cfg_hit) begin
         sel_cls = CLS_CFG;
         sel_tgt = CFG_TGT;
      end else if (snoop && sram_hit) begin
         sel_cls = CLS_SRAM;
         sel_tgt = sram_tgt;
         sel_idx = sram_idx;
      end else if (law_hit) begin
         sel_cls = CLS_LAW;
         sel_tgt = law_tgt;
         sel_idx = law_idx;
      end else if (boot_hit) begin
         sel_cls = CLS_BOOT;
         sel_tgt = BOOT_TGT;
      end
   end

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
   import awd_pkg::*;
#(
   parameter int                ADDR_W         = 36,
   parameter int                TGT_W          = 5,
   parameter int                NUM_LAW        = 8,
   parameter int                NUM_SRAM       = 2,
   parameter int                IDX_W          = (NUM_LAW > NUM_SRAM) ?
                                                 ((NUM_LAW > 1) ? $clog2(NUM_LAW) : 1) :
                                                 ((NUM_SRAM > 1) ? $clog2(NUM_SRAM) : 1),
   parameter int                LAW_CODE_MIN   = 11,
   parameter int                LAW_CODE_MAX   = ADDR_W - 1,
   parameter int                SRAM_CODE_MIN  = 15,
   parameter int                SRAM_CODE_MAX  = 17,
   parameter int                CFG_LOG2       = 20,
   parameter logic [ADDR_W-1:0] CFG_RESET_BASE = 36'h0_FF70_0000,
   parameter logic [TGT_W-1:0]  CFG_TGT        = 5'h1F,
   parameter int                BOOT_LOG2      = 23,
   parameter logic [ADDR_W-1:0] BOOT_BASE      = 36'hF_FF80_0000,
   parameter logic [TGT_W-1:0]  BOOT_TGT       = 5'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_snoop,
   input  logic              wr_valid,
   input  logic [1:0]        wr_class,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [SZ_W-1:0]   wr_size,
   input  logic              wr_enable,
   input  logic [TGT_W-1:0]  wr_target,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic              resp_miss,
   output logic [2:0]        resp_class,
   output logic [TGT_W-1:0]  resp_target,
   output logic [IDX_W-1:0]  resp_index
);

   localparam logic [ADDR_W-1:0] BOOT_KEEP = {ADDR_W{1'b1}} << BOOT_LOG2;

   // elaboration-time parameter checks
   if (ADDR_W < 24 || ADDR_W > 60) begin : g_bad_addr_w
      $error("addr_window_decoder: ADDR_W out of range");
   end
   if (NUM_LAW < 1 || NUM_SRAM < 1) begin : g_bad_count
      $error("addr_window_decoder: window counts must be at least one");
   end
   if ((1 << IDX_W) < NUM_LAW || (1 << IDX_W) < NUM_SRAM) begin : g_bad_idx_w
      $error("addr_window_decoder: IDX_W too narrow");
   end
   if (CFG_LOG2 >= ADDR_W || BOOT_LOG2 >= ADDR_W) begin : g_bad_fixed
      $error("addr_window_decoder: fixed window larger than address space");
   end
   if (LAW_CODE_MAX > ADDR_W - 1 || SRAM_CODE_MAX > ADDR_W - 1 ||
       LAW_CODE_MIN > LAW_CODE_MAX || SRAM_CODE_MIN > SRAM_CODE_MAX) begin : g_bad_codes
      $error("addr_window_decoder: size code range inconsistent");
   end

   logic             cfg_hit, sram_hit, law_hit, boot_hit;
   logic [IDX_W-1:0] sram_idx, law_idx;
   logic [TGT_W-1:0] sram_tgt, law_tgt;
   resp_cls_e        sel_cls;
   logic [TGT_W-1:0] sel_tgt;
   logic [IDX_W-1:0] sel_idx;

   awd_cfg_win #(
      .ADDR_W     (ADDR_W),
      .LOG2       (CFG_LOG2),
      .RESET_BASE (CFG_RESET_BASE)
   ) cfg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_valid && (wr_class == WR_CFG)),
      .wr_base (wr_base),
      .lk_addr (req_addr),
      .lk_hit  (cfg_hit)
   );

   awd_win_bank #(
      .ADDR_W   (ADDR_W),
      .TGT_W    (TGT_W),
      .NUM_WIN  (NUM_SRAM),
      .IDX_W    (IDX_W),
      .CODE_MIN (SRAM_CODE_MIN),
      .CODE_MAX (SRAM_CODE_MAX)
   ) sram_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_valid && (wr_class == WR_SRAM)),
      .wr_idx    (wr_idx),
      .wr_base   (wr_base),
      .wr_size   (wr_size),
      .wr_enable (wr_enable),
      .wr_target (wr_target),
      .lk_addr   (req_addr),
      .lk_hit    (sram_hit),
      .lk_idx    (sram_idx),
      .lk_tgt    (sram_tgt)
   );

   awd_win_bank #(
      .ADDR_W   (ADDR_W),
      .TGT_W    (TGT_W),
      .NUM_WIN  (NUM_LAW),
      .IDX_W    (IDX_W),
      .CODE_MIN (LAW_CODE_MIN),
      .CODE_MAX (LAW_CODE_MAX)
   ) law_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_valid && (wr_class == WR_LAW)),
      .wr_idx    (wr_idx),
      .wr_base   (wr_base),
      .wr_size   (wr_size),
      .wr_enable (wr_enable),
      .wr_target (wr_target),
      .lk_addr   (req_addr),
      .lk_hit    (law_hit),
      .lk_idx    (law_idx),
      .lk_tgt    (law_tgt)
   );

   assign boot_hit = ((req_addr ^ BOOT_BASE) & BOOT_KEEP) == '0;

   awd_select #(
      .TGT_W    (TGT_W),
      .IDX_W    (IDX_W),
      .CFG_TGT  (CFG_TGT),
      .BOOT_TGT (BOOT_TGT)
   ) sel_i (
      .snoop    (req_snoop),
      .cfg_hit  (cfg_hit),
      .sram_hit (sram_hit),
      .sram_idx (sram_idx),
      .sram_tgt (sram_tgt),
      .law_hit  (law_hit),
      .law_idx  (law_idx),
      .law_tgt  (law_tgt),
      .boot_hit (boot_hit),
      .sel_cls  (sel_cls),
      .sel_tgt  (sel_tgt),
      .sel_idx  (sel_idx)
   );

   // result register
   logic             vld_q;
   resp_cls_e        cls_q;
   logic [TGT_W-1:0] tgt_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         cls_q <= CLS_MISS;
         tgt_q <= '0;
         idx_q <= '0;
      end else begin
         vld_q <= req_valid;
         cls_q <= req_valid ? sel_cls : CLS_MISS;
         tgt_q <= req_valid ? sel_tgt : '0;
         idx_q <= req_valid ? sel_idx : '0;
      end
   end

   assign resp_valid  = vld_q;
   assign resp_hit    = vld_q && (cls_q != CLS_MISS);
   assign resp_miss   = vld_q && (cls_q == CLS_MISS);
   assign resp_class  = cls_q;
   assign resp_target = tgt_q;
   assign resp_index  = idx_q;

endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
   parameter int               TGT_W   = 5,
   parameter int               IDX_W   = 3,
   parameter logic [TGT_W-1:0] CFG_TGT = '1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_snoop,
   input logic             resp_valid,
   input logic             resp_hit,
   input logic             resp_miss,
   input logic [2:0]       resp_class,
   input logic [TGT_W-1:0] resp_target,
   input logic [IDX_W-1:0] resp_index
);

   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!resp_valid && !resp_hit && !resp_miss && resp_class == 3'd0
                      && resp_target == '0 && resp_index == '0));

   // R11
   hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (resp_hit != resp_miss));

   // R11
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_miss |-> (resp_class == 3'd0 && resp_target == '0 && resp_index == '0));

   // R5
   no_sram_nosnoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_snoop) |=> (resp_class != 3'd2));

   // R2
   cfg_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_class == 3'd1) |-> (resp_target == CFG_TGT && resp_index == '0));

endmodule

bind addr_window_decoder awd_checker #(
   .TGT_W   (TGT_W),
   .IDX_W   (IDX_W),
   .CFG_TGT (CFG_TGT)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_snoop   (req_snoop),
   .resp_valid  (resp_valid),
   .resp_hit    (resp_hit),
   .resp_miss   (resp_miss),
   .resp_class  (resp_class),
   .resp_target (resp_target),
   .resp_index  (resp_index)
);

// File: tb/addr_window_decoder_tb_top.sv
module addr_window_decoder_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NL = 8;
   localparam int NS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [35:0] req_addr = '0;
   logic        req_snoop = 1'b0;
   logic        wr_valid = 1'b0;
   logic [1:0]  wr_class = '0;
   logic [2:0]  wr_idx = '0;
   logic [35:0] wr_base = '0;
   logic [5:0]  wr_size = '0;
   logic        wr_enable = 1'b0;
   logic [4:0]  wr_target = '0;
   logic        resp_valid, resp_hit, resp_miss;
   logic [2:0]  resp_class;
   logic [4:0]  resp_target;
   logic [2:0]  resp_index;

   always #(CLK_PERIOD / 2) clk = ~clk;

   addr_window_decoder dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .req_snoop   (req_snoop),
      .wr_valid    (wr_valid),
      .wr_class    (wr_class),
      .wr_idx      (wr_idx),
      .wr_base     (wr_base),
      .wr_size     (wr_size),
      .wr_enable   (wr_enable),
      .wr_target   (wr_target),
      .resp_valid  (resp_valid),
      .resp_hit    (resp_hit),
      .resp_miss   (resp_miss),
      .resp_class  (resp_class),
      .resp_target (resp_target),
      .resp_index  (resp_index)
   );

   // ---------------- reference model ----------------
   longint unsigned m_cfg;
   longint unsigned m_lbase [NL];
   int              m_lcode [NL];
   bit              m_len   [NL];
   int              m_ltgt  [NL];
   longint unsigned m_sbase [NS];
   int              m_scode [NS];
   bit              m_sen   [NS];
   int              m_stgt  [NS];

   bit e_valid = 0;
   int e_cls = 0, e_tgt = 0, e_idx = 0;

   int    n_chk = 0, n_fail = 0;
   bit    chk_on = 0;
   bit    done = 0;
   string cur_tag = "R1 reset";

   function automatic bit win_hit(longint unsigned a, longint unsigned b, int code,
                                  bit en, int lo, int hi);
      if (!en || code < lo || code > hi) return 0;
      return (a >> (code + 1)) == (b >> (code + 1));
   endfunction

   function automatic void model_reset();
      m_cfg = 64'h0_FF70_0000;
      foreach (m_lbase[i]) begin m_lbase[i] = 0; m_lcode[i] = 0; m_len[i] = 0; m_ltgt[i] = 0; end
      foreach (m_sbase[i]) begin m_sbase[i] = 0; m_scode[i] = 0; m_sen[i] = 0; m_stgt[i] = 0; end
   endfunction

   function automatic void model_lookup(longint unsigned a, bit snp,
                                        output int cls, output int tgt, output int idx);
      cls = 0; tgt = 0; idx = 0;
      if ((a >> 20) == (m_cfg >> 20)) begin cls = 1; tgt = 'h1F; return; end
      if (snp) begin
         for (int i = 0; i < NS; i++)
            if (win_hit(a, m_sbase[i], m_scode[i], m_sen[i], 15, 17)) begin
               cls = 2; tgt = m_stgt[i]; idx = i; return;
            end
      end
      for (int i = 0; i < NL; i++)
         if (win_hit(a, m_lbase[i], m_lcode[i], m_len[i], 11, 35)) begin
            cls = 3; tgt = m_ltgt[i]; idx = i; return;
         end
      if ((a >> 23) == (64'hF_FF80_0000 >> 23)) begin cls = 4; tgt = 'h0F; end
   endfunction

   function automatic longint unsigned align(longint unsigned b, int code, int lo, int hi);
      if (code < lo || code > hi) return b;
      return b & ~((64'd1 << (code + 1)) - 1);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         model_reset();
         e_valid = 0; e_cls = 0; e_tgt = 0; e_idx = 0;
      end else begin
         e_valid = req_valid;
         if (req_valid) model_lookup(64'(req_addr), req_snoop, e_cls, e_tgt, e_idx);
         else begin e_cls = 0; e_tgt = 0; e_idx = 0; end
         if (wr_valid) begin
            case (wr_class)
               2'd0: m_cfg = 64'(wr_base) & ~64'hF_FFFF;
               2'd1: if (int'(wr_idx) < NS) begin
                  m_sbase[wr_idx] = align(64'(wr_base), int'(wr_size), 15, 17);
                  m_scode[wr_idx] = int'(wr_size);
                  m_sen[wr_idx]   = wr_enable;
                  m_stgt[wr_idx]  = int'(wr_target);
               end
               2'd2: begin
                  m_lbase[wr_idx] = align(64'(wr_base), int'(wr_size), 11, 35);
                  m_lcode[wr_idx] = int'(wr_size);
                  m_len[wr_idx]   = wr_enable;
                  m_ltgt[wr_idx]  = int'(wr_target);
               end
               default: ;
            endcase
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (chk_on && !done) begin
         n_chk++;
         if (resp_valid !== e_valid || resp_hit !== (e_valid && e_cls != 0) ||
             resp_miss !== (e_valid && e_cls == 0) || int'(resp_class) != e_cls ||
             int'(resp_target) != e_tgt || int'(resp_index) != e_idx) begin
            n_fail++;
            $display("FAIL %s: actual v=%0b h=%0b m=%0b cls=%0d tgt=%0h idx=%0d, expected v=%0b cls=%0d tgt=%0h idx=%0d",
                     cur_tag, resp_valid, resp_hit, resp_miss, resp_class, resp_target,
                     resp_index, e_valid, e_cls, e_tgt, e_idx);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic idle();
      req_valid = 0; wr_valid = 0;
      @(negedge clk);
   endtask

   task automatic wr(int cls, int idx, longint unsigned base, int code, bit en, int tgt);
      wr_valid = 1; wr_class = 2'(cls); wr_idx = 3'(idx); wr_base = 36'(base);
      wr_size = 6'(code); wr_enable = en; wr_target = 5'(tgt);
      @(negedge clk);
      wr_valid = 0;
   endtask

   task automatic rq(string tag, longint unsigned a, bit snp);
      cur_tag = tag;
      req_valid = 1; req_addr = 36'(a); req_snoop = snp;
      @(negedge clk);
      req_valid = 0;
      @(negedge clk);   // response compared at this edge
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual hung run, expected completion");
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk_on = 1;
      cur_tag = "R1 reset state";
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R10 boot region, R11 miss
      rq("R10 boot region", 64'hF_FF80_0010, 1);
      rq("R11 miss", 64'h0_0000_1000, 0);

      // R2 configuration window
      rq("R2 cfg reset base", 64'h0_FF70_0123, 0);
      wr(0, 0, 64'h1_2345_6789, 0, 0, 0);
      rq("R2 cfg top of window", 64'h1_234F_FFFF, 1);
      rq("R2 cfg just above", 64'h1_2350_0000, 1);
      rq("R2 cfg old base", 64'h0_FF70_0000, 0);

      // R7 overlapping local access windows
      wr(2, 0, 64'h0_0000_0000, 30, 1, 3);
      wr(2, 1, 64'h0_4000_0000, 19, 1, 7);
      rq("R7 overlap lowest wins", 64'h0_4000_0100, 0);
      wr(2, 0, 64'h0_0000_0000, 30, 0, 3);
      rq("R7 disabled falls to next", 64'h0_4000_0100, 1);
      rq("R7 above window", 64'h0_4010_0000, 0);

      // R8 size code legality
      wr(2, 2, 64'h8_0000_0000, 10, 1, 9);
      rq("R8 code below minimum", 64'h8_0000_0000, 0);
      wr(2, 2, 64'h8_0000_0000, 11, 1, 9);
      rq("R8 code at minimum", 64'h8_0000_0FFF, 0);
      rq("R8 past 4KB", 64'h8_0000_1000, 0);
      wr(2, 2, 64'h8_0000_0000, 36, 1, 9);
      rq("R8 code above maximum", 64'h8_0000_0000, 0);

      // R9 unaligned base
      wr(2, 3, 64'h2_0000_0ABC, 11, 1, 4);
      rq("R9 aligned start", 64'h2_0000_0000, 0);
      rq("R9 next block", 64'h2_0000_1000, 0);

      // R4 and R5 SRAM over local access
      wr(1, 0, 64'h0_4000_0000, 16, 1, 'h12);
      rq("R4 snooped SRAM", 64'h0_4001_0000, 1);
      rq("R5 non-snooped to LAW", 64'h0_4001_0000, 0);
      rq("R4 outside 128KB", 64'h0_4002_0000, 1);

      // R6 SRAM sizes
      wr(1, 1, 64'h3_0000_0000, 14, 1, 'h13);
      rq("R6 SRAM code 14", 64'h3_0000_0000, 1);
      wr(1, 1, 64'h3_0000_0000, 18, 1, 'h13);
      rq("R6 SRAM code 18", 64'h3_0000_0000, 1);
      wr(1, 1, 64'h3_0000_0000, 17, 1, 'h13);
      rq("R6 SRAM code 17 top", 64'h3_0003_FFFF, 1);
      rq("R6 SRAM past 256KB", 64'h3_0004_0000, 1);

      // R3 configuration over SRAM and LAW
      wr(1, 0, 64'h1_2340_0000, 15, 1, 'h12);
      wr(2, 4, 64'h1_0000_0000, 30, 1, 6);
      rq("R3 cfg over SRAM", 64'h1_2340_0004, 1);
      rq("R3 cfg over LAW", 64'h1_2340_0004, 0);
      wr(0, 0, 64'h0_FF70_0000, 0, 0, 0);
      rq("R4 SRAM after cfg moved", 64'h1_2340_0004, 1);
      rq("R5 LAW after cfg moved", 64'h1_2340_0004, 0);

      // R12 ignored writes and same-cycle ordering
      wr(1, 2, 64'h5_0000_0000, 16, 1, 1);
      wr(3, 5, 64'h5_0000_0000, 20, 1, 1);
      rq("R12 ignored writes", 64'h5_0000_0000, 1);
      cur_tag = "R12 same-cycle write";
      req_valid = 1; req_addr = 36'h5_0000_0000; req_snoop = 0;
      wr(2, 5, 64'h5_0000_0000, 20, 1, 2);
      cur_tag = "R12 write visible next cycle";
      @(negedge clk);
      req_valid = 0;
      @(negedge clk);

      // random phase
      cur_tag = "R4/R7 random";
      for (int k = 0; k < 3000; k++) begin
         int pick;
         longint unsigned a;
         pick = int'($urandom_range(0, 9));
         a = {$urandom, $urandom} & 64'hF_FFFF_FFFF;
         if (pick < 4) a = m_lbase[$urandom_range(0, NL - 1)] + ($urandom & 32'h3_FFFF);
         else if (pick < 7) a = m_sbase[$urandom_range(0, NS - 1)] + ($urandom & 32'h7_FFFF);
         else if (pick == 7) a = m_cfg + ($urandom & 32'h1F_FFFF) - 32'h8_0000;
         req_valid = ($urandom_range(0, 3) != 0);
         req_addr  = 36'(a);
         req_snoop = $urandom_range(0, 1) == 1;
         wr_valid  = ($urandom_range(0, 7) == 0);
         wr_class  = ($urandom_range(0, 15) == 0) ? 2'($urandom_range(0, 3))
                                                  : 2'($urandom_range(1, 2));
         wr_idx    = 3'($urandom_range(0, 7));
         wr_base   = 36'(a ^ 64'($urandom_range(0, 'h3FFF)));
         wr_size   = ($urandom_range(0, 1) == 1) ? 6'($urandom_range(14, 18))
                                                 : 6'($urandom_range(9, 37));
         wr_enable = $urandom_range(0, 4) != 0;
         wr_target = 5'($urandom);
         @(negedge clk);
      end
      req_valid = 0; wr_valid = 0;
      idle();
      idle();

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule